// File: doc/BRIEF.md
# ATA command word decoder

This block sits between a command queue and the cycle engine of a parallel ATA host port. It takes 16-bit command words, one at a time. Each word carries its operation in its upper bits. A word can read a device register, write a device register, start a bulk data transfer in either direction, or select the target device and the unit in which transfer counts are expressed. Register and data words become a single request to the cycle engine, which carries the chip-select pair, the register address, the write byte, the target device, the count unit and the transfer count.

Device selection is sticky: a select word updates internal state and issues no bus request, and every later request carries that state. A data transfer holds the request until the engine has reported one completion per transfer unit. A register read holds its returned byte in a one-entry response stage until the consumer takes it. A 32-bit status word reports the selected device, transfer activity, the remaining count, an illegal-command flag and three status lines passed through from outside.

Top module: `ata_cmd_decoder`

## Requirements
- R1: A word with bits [15:13] = 3'b001 issues a register read (`req_kind` = 2'b00) with `req_cs` = bits [12:11], `req_addr` = bits [10:8] and `req_wdata` = 0, whatever its low byte holds.
- R2: A word with bits [15:13] = 3'b101 issues a register write (`req_kind` = 2'b01) with `req_cs` = bits [12:11], `req_addr` = bits [10:8] and `req_wdata` = bits [7:0].
- R3: A word with bits [14:13] = 2'b10 issues a data transfer, with `req_kind` = 2'b10 when bit 15 is 0 (read) and 2'b11 when bit 15 is 1 (write). `req_count` and status bits [29:16] both take bits [12:0] (transfers minus one), up to the largest value 0x1FFF.
- R4: A word whose bits [15:2] equal 14'h2740 (0x9D00 with the low two bits clear) issues no request. It sets the device to bit 0 and the block unit to bit 1. Both values appear on `req_dev` / `req_blocks` of every later request and on status bit 11 (device).
- R5: After reset, `cmd_ready` is 1, `req_valid` and `rd_valid` are 0, the device is 0 with byte units, and status reads 0 when the pass-through inputs are 0.
- R6: A word that matches no pattern issues no request and leaves the device setting unchanged. It sets status bit 30, which stays set until reset.
- R7: While a request is outstanding, `cmd_ready` is 0 and the request fields hold steady. A register request ends on the first `eng_done` pulse.
- R8: During a data transfer, each `eng_done` lowers the status count by one. The `eng_done` that arrives with the count at 0 ends the transfer. Status bit 12 is 1 for exactly the span of the transfer.
- R9: A register read's `eng_done` raises `rd_valid` with `rd_data` = {24'b0, `eng_rdata`}. The result is held, and `cmd_ready` stays 0, until `rd_ready` is seen.
- R10: Status bits 5, 14 and 15 follow `dev_irq`, `wfifo_full` and `rfifo_empty` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command queue holds a word |
| cmd_word | input | 16 | Command word |
| cmd_ready | output | 1 | Word is taken on this edge when valid |
| req_valid | output | 1 | Request outstanding to cycle engine |
| req_kind | output | 2 | 00 reg read, 01 reg write, 10 data read, 11 data write |
| req_cs | output | 2 | Chip-select pair |
| req_addr | output | 3 | Device register address |
| req_wdata | output | 8 | Byte for a register write |
| req_dev | output | 1 | Target device (0 master, 1 slave) |
| req_blocks | output | 1 | Count unit: 0 bytes, 1 eight-byte blocks |
| req_count | output | 13 | Transfers minus one |
| eng_done | input | 1 | Engine completion pulse |
| eng_rdata | input | 8 | Register byte returned with `eng_done` |
| rd_valid | output | 1 | Register read result waiting |
| rd_data | output | 32 | Register read result |
| rd_ready | input | 1 | Consumer takes the result |
| dev_irq | input | 1 | Device interrupt line |
| wfifo_full | input | 1 | Write queue full |
| rfifo_empty | input | 1 | Read queue empty |
| status | output | 32 | Status word |

## Verification
The assertions assume that the cycle engine pulses `eng_done` only while `req_valid` is high. They do not assume any restriction on `cmd_valid` or `rd_ready`. The directed stimulus raises `eng_done` only after the bench has seen a request, and always for a single cycle. Some words are presented while the decoder is busy, and the response stage is left waiting for several cycles. This exercises the back-pressure properties from the side that could break them.

// File: rtl/atacd_pkg.sv
package atacd_pkg;
    localparam int WORD_W     = 16;
    localparam int XFER_W     = 13;
    localparam int STAT_W     = 32;
    localparam int STAT_CNT_W = 14;
    localparam logic [13:0] SELDEV_PAT = 14'h2740;

    localparam int ST_IRQ_BIT    = 5;
    localparam int ST_DEV_BIT    = 11;
    localparam int ST_PIO_BIT    = 12;
    localparam int ST_WFULL_BIT  = 14;
    localparam int ST_REMPTY_BIT = 15;
    localparam int ST_CNT_LSB    = 16;
    localparam int ST_BAD_BIT    = 30;

    typedef enum logic [2:0] {
        OP_REG_RD, OP_REG_WR, OP_DAT_RD, OP_DAT_WR, OP_SEL_DEV, OP_BAD
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_BUSY, ST_RESP
    } st_e;

    typedef struct packed {
        logic [1:0]        cs;
        logic [2:0]        addr;
        logic [7:0]        wbyte;
        logic [XFER_W-1:0] xfer;
        logic              dev;
        logic              blk;
    } cmd_fields_t;
endpackage

// File: rtl/atacd_classify.sv
module atacd_classify
    import atacd_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output op_e               op_o,
    output cmd_fields_t       fld_o
);
    always_comb begin
        fld_o.cs    = word_i[12:11];
        fld_o.addr  = word_i[10:8];
        fld_o.wbyte = word_i[7:0];
        fld_o.xfer  = word_i[XFER_W-1:0];
        fld_o.dev   = word_i[0];
        fld_o.blk   = word_i[1];

        if (word_i[15:2] == SELDEV_PAT) begin
            op_o = OP_SEL_DEV;
        end else if (word_i[14:13] == 2'b10) begin
            op_o = word_i[15] ? OP_DAT_WR : OP_DAT_RD;
        end else if (word_i[15:13] == 3'b001) begin
            op_o = OP_REG_RD;
        end else if (word_i[15:13] == 3'b101) begin
            op_o = OP_REG_WR;
        end else begin
            op_o = OP_BAD;
        end
    end
endmodule

// File: rtl/atacd_xfer_cnt.sv
module atacd_xfer_cnt #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/atacd_status.sv
module atacd_status
    import atacd_pkg::*;
(
    input  logic                  dev_i,
    input  logic                  pio_i,
    input  logic                  irq_i,
    input  logic                  wfull_i,
    input  logic                  rempty_i,
    input  logic                  bad_i,
    input  logic [STAT_CNT_W-1:0] cnt_i,
    output logic [STAT_W-1:0]     stat_o
);
    always_comb begin
        stat_o                             = '0;
        stat_o[ST_IRQ_BIT]                 = irq_i;
        stat_o[ST_DEV_BIT]                 = dev_i;
        stat_o[ST_PIO_BIT]                 = pio_i;
        stat_o[ST_WFULL_BIT]               = wfull_i;
        stat_o[ST_REMPTY_BIT]              = rempty_i;
        stat_o[ST_CNT_LSB +: STAT_CNT_W]   = cnt_i;
        stat_o[ST_BAD_BIT]                 = bad_i;
    end
endmodule

// File: rtl/ata_cmd_decoder.sv
module ata_cmd_decoder
    import atacd_pkg::*;
#(
    parameter int RD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              cmd_ready,
    output logic              req_valid,
    output logic [1:0]        req_kind,
    output logic [1:0]        req_cs,
    output logic [2:0]        req_addr,
    output logic [7:0]        req_wdata,
    output logic              req_dev,
    output logic              req_blocks,
    output logic [XFER_W-1:0] req_count,
    input  logic              eng_done,
    input  logic [7:0]        eng_rdata,
    output logic              rd_valid,
    output logic [RD_W-1:0]   rd_data,
    input  logic              rd_ready,
    input  logic              dev_irq,
    input  logic              wfifo_full,
    input  logic              rfifo_empty,
    output logic [STAT_W-1:0] status
);
    localparam int RD_PAD = RD_W - 8;

    typedef struct packed {
        st_e               st;
        logic [1:0]        kind;
        logic [1:0]        cs;
        logic [2:0]        addr;
        logic [7:0]        wbyte;
        logic [XFER_W-1:0] count;
        logic              dev;
        logic              blk;
        logic              rq_dev;
        logic              rq_blk;
        logic              bad;
        logic [7:0]        rbyte;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    op_e                   op;
    cmd_fields_t           fld;
    logic                  cnt_load, cnt_dec, cnt_zero;
    logic [STAT_CNT_W-1:0] cnt;

    atacd_classify u_classify (
        .word_i (cmd_word),
        .op_o   (op),
        .fld_o  (fld)
    );

    atacd_xfer_cnt #(.W(STAT_CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .val_i  (STAT_CNT_W'(fld.xfer)),
        .dec_i  (cnt_dec),
        .cnt_o  (cnt),
        .zero_o (cnt_zero)
    );

    always_comb begin
        ctl_d    = ctl_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (op)
                        OP_SEL_DEV: begin
                            ctl_d.dev = fld.dev;
                            ctl_d.blk = fld.blk;
                        end
                        OP_REG_RD, OP_REG_WR: begin
                            ctl_d.st     = ST_BUSY;
                            ctl_d.kind   = (op == OP_REG_WR) ? 2'b01 : 2'b00;
                            ctl_d.cs     = fld.cs;
                            ctl_d.addr   = fld.addr;
                            ctl_d.wbyte  = (op == OP_REG_WR) ? fld.wbyte : 8'h00;
                            ctl_d.count  = '0;
                            ctl_d.rq_dev = ctl_q.dev;
                            ctl_d.rq_blk = ctl_q.blk;
                        end
                        OP_DAT_RD, OP_DAT_WR: begin
                            ctl_d.st     = ST_BUSY;
                            ctl_d.kind   = (op == OP_DAT_WR) ? 2'b11 : 2'b10;
                            ctl_d.cs     = 2'b00;
                            ctl_d.addr   = 3'b000;
                            ctl_d.wbyte  = 8'h00;
                            ctl_d.count  = fld.xfer;
                            ctl_d.rq_dev = ctl_q.dev;
                            ctl_d.rq_blk = ctl_q.blk;
                            cnt_load     = 1'b1;
                        end
                        default: ctl_d.bad = 1'b1;
                    endcase
                end
            end
            ST_BUSY: begin
                if (eng_done) begin
                    case (ctl_q.kind)
                        2'b00: begin
                            ctl_d.rbyte = eng_rdata;
                            ctl_d.st    = ST_RESP;
                        end
                        2'b01: ctl_d.st = ST_IDLE;
                        default: begin
                            if (cnt_zero) ctl_d.st = ST_IDLE;
                            else          cnt_dec  = 1'b1;
                        end
                    endcase
                end
            end
            ST_RESP: begin
                if (rd_ready) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_ready  = (ctl_q.st == ST_IDLE);
    assign req_valid  = (ctl_q.st == ST_BUSY);
    assign req_kind   = ctl_q.kind;
    assign req_cs     = ctl_q.cs;
    assign req_addr   = ctl_q.addr;
    assign req_wdata  = ctl_q.wbyte;
    assign req_dev    = ctl_q.rq_dev;
    assign req_blocks = ctl_q.rq_blk;
    assign req_count  = ctl_q.count;
    assign rd_valid   = (ctl_q.st == ST_RESP);
    assign rd_data    = {{RD_PAD{1'b0}}, ctl_q.rbyte};

    atacd_status u_status (
        .dev_i    (ctl_q.dev),
        .pio_i    ((ctl_q.st == ST_BUSY) && ctl_q.kind[1]),
        .irq_i    (dev_irq),
        .wfull_i  (wfifo_full),
        .rempty_i (rfifo_empty),
        .bad_i    (ctl_q.bad),
        .cnt_i    (cnt),
        .stat_o   (status)
    );
endmodule

// File: rtl/atacd_chk.sv
module atacd_chk
    import atacd_pkg::*;
#(
    parameter int RD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [1:0]        req_cs,
    input logic [2:0]        req_addr,
    input logic [7:0]        req_wdata,
    input logic [XFER_W-1:0] req_count,
    input logic              eng_done,
    input logic              rd_valid,
    input logic [RD_W-1:0]   rd_data,
    input logic              rd_ready,
    input logic              cmd_valid,
    input logic [STAT_W-1:0] status
);
    // R7
    req_blocks_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !cmd_ready);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !eng_done) |=> (req_valid && $stable(req_kind) && $stable(req_cs)
                                      && $stable(req_addr) && $stable(req_wdata)
                                      && $stable(req_count)));

    // R6
    bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_BAD_BIT] |=> status[ST_BAD_BIT]);

    // R4
    dev_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> $stable(status[ST_DEV_BIT]));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind[1] && eng_done && status[ST_CNT_LSB +: STAT_CNT_W] != '0)
        |=> (status[ST_CNT_LSB +: STAT_CNT_W] == $past(status[ST_CNT_LSB +: STAT_CNT_W]) - 1'b1));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && !cmd_ready));

    // R9
    rd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[RD_W-1:8] == '0));

    // R8
    pio_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_PIO_BIT] |-> (req_valid && req_kind[1]));
endmodule

bind ata_cmd_decoder atacd_chk #(.RD_W(RD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_cs    (req_cs),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_count (req_count),
    .eng_done  (eng_done),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_ready  (rd_ready),
    .cmd_valid (cmd_valid),
    .status    (status)
);

// File: tb/ata_cmd_decoder_bench.sv
module ata_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        cmd_ready;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [1:0]  req_cs;
    logic [2:0]  req_addr;
    logic [7:0]  req_wdata;
    logic        req_dev;
    logic        req_blocks;
    logic [12:0] req_count;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_rdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rd_ready = 1'b0;
    logic        dev_irq = 1'b0;
    logic        wfifo_full = 1'b0;
    logic        rfifo_empty = 1'b0;
    logic [31:0] status;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ata_cmd_decoder u_ata_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_ready(cmd_ready), .req_valid(req_valid), .req_kind(req_kind),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_dev(req_dev), .req_blocks(req_blocks), .req_count(req_count),
        .eng_done(eng_done), .eng_rdata(eng_rdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_ready(rd_ready), .dev_irq(dev_irq),
        .wfifo_full(wfifo_full), .rfifo_empty(rfifo_empty), .status(status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h, expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_done(input logic [7:0] b);
        eng_done  = 1'b1;
        eng_rdata = b;
        @(negedge clk);
        eng_done  = 1'b0;
    endtask

    task automatic t_reset;
        chk("R5 cmd_ready", 32'(cmd_ready), 32'd1);
        chk("R5 req_valid", 32'(req_valid), 32'd0);
        chk("R5 rd_valid", 32'(rd_valid), 32'd0);
        chk("R5 status", status, 32'h0);
    endtask

    task automatic t_reg_read;
        push(16'h2000 | (16'd2 << 11) | (16'd5 << 8) | 16'h00AB);
        chk("R1 req_valid", 32'(req_valid), 32'd1);
        chk("R1 kind", 32'(req_kind), 32'd0);
        chk("R1 cs", 32'(req_cs), 32'd2);
        chk("R1 addr", 32'(req_addr), 32'd5);
        chk("R1 low byte ignored", 32'(req_wdata), 32'd0);
        chk("R5 dev after reset", 32'(req_dev), 32'd0);
        chk("R5 unit after reset", 32'(req_blocks), 32'd0);
        cmd_valid = 1'b1;
        cmd_word  = 16'hA000;
        repeat (3) @(negedge clk);
        chk("R7 held req_valid", 32'(req_valid), 32'd1);
        chk("R7 no pop while busy", 32'(cmd_ready), 32'd0);
        chk("R7 held addr", 32'(req_addr), 32'd5);
        pulse_done(8'h5A);
        chk("R9 rd_valid", 32'(rd_valid), 32'd1);
        chk("R9 rd_data", rd_data, 32'h0000_005A);
        chk("R9 req dropped", 32'(req_valid), 32'd0);
        repeat (2) @(negedge clk);
        chk("R9 held rd_data", rd_data, 32'h0000_005A);
        chk("R9 no pop in resp", 32'(cmd_ready), 32'd0);
        cmd_valid = 1'b0;
        rd_ready  = 1'b1;
        @(negedge clk);
        rd_ready  = 1'b0;
        chk("R9 rd_valid after take", 32'(rd_valid), 32'd0);
        chk("R9 ready after take", 32'(cmd_ready), 32'd1);
    endtask

    task automatic t_reg_write;
        push(16'hA000 | (16'd1 << 11) | (16'd3 << 8) | 16'h007E);
        chk("R2 kind", 32'(req_kind), 32'd1);
        chk("R2 cs", 32'(req_cs), 32'd1);
        chk("R2 addr", 32'(req_addr), 32'd3);
        chk("R2 wdata", 32'(req_wdata), 32'h7E);
        pulse_done(8'hFF);
        chk("R7 write ends on done", 32'(req_valid), 32'd0);
        chk("R7 write no response", 32'(rd_valid), 32'd0);
        chk("R7 ready after write", 32'(cmd_ready), 32'd1);
    endtask

    task automatic t_set_dev_and_data;
        push(16'h9D03);
        chk("R4 no request", 32'(req_valid), 32'd0);
        chk("R4 status dev", 32'(status[11]), 32'd1);
        push(16'h4002);
        chk("R3 kind read", 32'(req_kind), 32'd2);
        chk("R3 count", 32'(req_count), 32'd2);
        chk("R3 status count", 32'(status[29:16]), 32'd2);
        chk("R4 sticky dev", 32'(req_dev), 32'd1);
        chk("R4 sticky unit", 32'(req_blocks), 32'd1);
        chk("R8 pio flag", 32'(status[12]), 32'd1);
        pulse_done(8'h00);
        chk("R8 count step", 32'(status[29:16]), 32'd1);
        pulse_done(8'h00);
        chk("R8 count zero", 32'(status[29:16]), 32'd0);
        chk("R8 still active", 32'(req_valid), 32'd1);
        pulse_done(8'h00);
        chk("R8 end of transfer", 32'(req_valid), 32'd0);
        chk("R8 pio flag cleared", 32'(status[12]), 32'd0);
        push(16'h9D00);
        chk("R4 dev back", 32'(status[11]), 32'd0);
        push(16'hC000);
        chk("R3 kind write", 32'(req_kind), 32'd3);
        chk("R3 count zero", 32'(req_count), 32'd0);
        chk("R4 dev master", 32'(req_dev), 32'd0);
        chk("R4 unit bytes", 32'(req_blocks), 32'd0);
        pulse_done(8'h00);
        chk("R8 single unit ends", 32'(req_valid), 32'd0);
    endtask

    task automatic t_max_count;
        push(16'h5FFF);
        chk("R3 max count", 32'(req_count), 32'h1FFF);
        chk("R3 max status count", 32'(status[29:16]), 32'h1FFF);
        for (int i = 0; i < 8191; i++) pulse_done(8'h00);
        chk("R8 max still active", 32'(req_valid), 32'd1);
        chk("R8 max count zero", 32'(status[29:16]), 32'd0);
        pulse_done(8'h00);
        chk("R8 max ends", 32'(req_valid), 32'd0);
    endtask

    task automatic t_illegal;
        chk("R6 flag clear before", 32'(status[30]), 32'd0);
        push(16'h0123);
        chk("R6 no request", 32'(req_valid), 32'd0);
        chk("R6 flag set", 32'(status[30]), 32'd1);
        push(16'h9D05);
        chk("R6 near-select ignored", 32'(status[11]), 32'd0);
        chk("R6 near-select no request", 32'(req_valid), 32'd0);
        push(16'h8000);
        chk("R6 still ready", 32'(cmd_ready), 32'd1);
        push(16'hA000 | 16'h0011);
        chk("R6 legal after bad", 32'(req_wdata), 32'h11);
        pulse_done(8'h00);
        chk("R6 flag sticky", 32'(status[30]), 32'd1);
    endtask

    task automatic t_passthrough;
        dev_irq = 1'b1; wfifo_full = 1'b1; rfifo_empty = 1'b1;
        #1;
        chk("R10 irq bit", 32'(status[5]), 32'd1);
        chk("R10 wfull bit", 32'(status[14]), 32'd1);
        chk("R10 rempty bit", 32'(status[15]), 32'd1);
        wfifo_full = 1'b0;
        #1;
        chk("R10 wfull low", 32'(status[14]), 32'd0);
        dev_irq = 1'b0; rfifo_empty = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_read();
        t_reg_write();
        t_set_dev_and_data();
        t_max_count();
        t_illegal();
        t_passthrough();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog: got hang, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule